// File: doc/BRIEF.md
# Mode-Selectable Floating-Point NaN Propagation Unit

This unit decides what a floating-point operation returns when one or more of its operands is Not-a-Number. It accepts raw IEEE-754 operand encodings (binary32 by default; binary16 or any other width through the exponent and fraction parameters), a flag that says whether the operation is a two-operand operation or a fused multiply-add `a*b+c`, and a mode bit. From these it reports whether a NaN result applies, which NaN bit pattern to return, and whether the invalid-operation exception must be raised. Arithmetic, rounding, tininess and flush-to-zero are handled elsewhere. When `nan_valid` is low, the datapath uses its own arithmetic result.

The mode bit selects one of two complete rule sets. The standard rule set ranks signalling NaNs ahead of quiet ones and, for multiply-add, ranks the addend first. The alternate rule set returns the first NaN in operand order. The two rule sets also differ in how they handle zero times infinity plus NaN and in the sign of the default NaN. The mode is sampled with each operation's operands and the unit holds no state other than the optional output register. Changing the mode between operations therefore only affects the operations that follow.

Top module: `nanprop_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. It is quiet when the fraction MSB is 1 and signalling otherwise. `nan_valid` is 1 exactly when an active operand is a NaN or the zero-times-infinity case of R7/R8 applies. When `nan_valid` is 0, both `nan_result` and `invalid` are 0. `op_a` and `op_b` are always active. `op_c` is active only when `three_op`=1.
- R2: The returned NaN is always quiet. A selected signalling NaN keeps its sign and lower payload bits and gets its fraction MSB forced to 1.
- R3: Standard mode (`alt_mode`=0), two operands (`three_op`=0): the first match wins in this order: signalling A, signalling B, quiet A, quiet B.
- R4: Standard mode, multiply-add (`three_op`=1): signalling NaNs win over quiet NaNs. Within each class the order is C, then A, then B.
- R5: Alternate mode (`alt_mode`=1), two operands: A is returned if it is a NaN of either kind, otherwise B.
- R6: Alternate mode, multiply-add: the first NaN in the order A, B, C is returned, regardless of kind.
- R7: Standard mode, multiply-add, with one product operand ±0, the other ±infinity, and C a NaN: the result is the default NaN if C is quiet, or quieted C if C is signalling. `invalid`=1 in both cases.
- R8: Alternate mode, same operand case as R7: the result is always quieted C. `invalid` is 1 only when C is signalling.
- R9: `default_nan` has an all-ones exponent, fraction MSB 1 and all other fraction bits 0. Its sign bit equals the mode (0 standard, 1 alternate).
- R10: `invalid` is 1 whenever any active operand is a signalling NaN, in both modes.
- R11: With `REG_OUT`=1, every output reflects the inputs presented one clock earlier. An active-low reset clears all outputs to 0. Consecutive operations may alternate mode with no carry-over from one to the next.
- R12: With `three_op`=0, `op_c` has no effect on any output, even when it is a signalling NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 1+EXP_W+FRAC_W | Operand A (first multiplicand for multiply-add) |
| op_b | input | 1+EXP_W+FRAC_W | Operand B (second multiplicand) |
| op_c | input | 1+EXP_W+FRAC_W | Operand C (addend), used only when three_op=1 |
| three_op | input | 1 | 1 = multiply-add a*b+c, 0 = two-operand operation |
| alt_mode | input | 1 | 0 = standard rules, 1 = alternate rules |
| nan_valid | output | 1 | A NaN result applies to this operation |
| nan_result | output | 1+EXP_W+FRAC_W | Selected quiet NaN or default NaN |
| invalid | output | 1 | Invalid-operation exception |
| default_nan | output | 1+EXP_W+FRAC_W | Default NaN pattern for the sampled mode |

## Verification
The bench builds two copies of the unit. The first uses the default binary32 fields with the output register present, which brings the one-cycle latency, the reset clearing of the outputs and back-to-back mode switching within reach. The second uses binary16 fields (5-bit exponent, 10-bit fraction) with no register. This shows that quieting, the default NaN pattern and the zero-times-infinity detection follow the field positions given by the parameters, and it exercises the purely combinational path.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_ALT = 1'b1
    } nan_mode_e;

    typedef enum logic [2:0] {
        PICK_NONE = 3'd0,
        PICK_A    = 3'd1,
        PICK_B    = 3'd2,
        PICK_C    = 3'd3,
        PICK_DFLT = 3'd4
    } nan_pick_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } nan_flags_t;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] operand,
    output nan_flags_t   flags,
    output logic [W-1:0] quieted
);

    logic exp_all_ones;
    logic frac_nonzero;

    assign exp_all_ones  = &operand[W-2:FRAC_W];
    assign frac_nonzero  = |operand[FRAC_W-1:0];

    assign flags.is_nan  = exp_all_ones & frac_nonzero;
    assign flags.is_snan = exp_all_ones & frac_nonzero & ~operand[FRAC_W-1];

    // Keep sign, exponent and lower payload; force the quiet bit.
    generate
        if (FRAC_W > 1) begin : g_wide
            assign quieted = {operand[W-1:FRAC_W], 1'b1, operand[FRAC_W-2:0]};
        end else begin : g_narrow
            assign quieted = {operand[W-1:FRAC_W], 1'b1};
        end
    endgenerate

endmodule

// File: rtl/nanprop_zero_inf.sv
module nanprop_zero_inf #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    output logic         zero_times_inf
);

    logic [1:0] is_zero;
    logic [1:0] is_inf;
    logic [W-1:0] mul_ops [2];

    assign mul_ops[0] = mul_a;
    assign mul_ops[1] = mul_b;

    for (genvar k = 0; k < 2; k++) begin : g_op
        assign is_zero[k] = ~|mul_ops[k][W-2:0];
        assign is_inf[k]  = (&mul_ops[k][W-2:FRAC_W]) & ~|mul_ops[k][FRAC_W-1:0];
    end

    assign zero_times_inf = (is_zero[0] & is_inf[1]) | (is_inf[0] & is_zero[1]);

endmodule

// File: rtl/nanprop_select.sv
module nanprop_select
    import nanprop_pkg::*;
(
    input  nan_flags_t fl_a,
    input  nan_flags_t fl_b,
    input  nan_flags_t fl_c,
    input  logic       three_op,
    input  nan_mode_e  mode,
    input  logic       zero_times_inf,
    output nan_pick_e  pick,
    output logic       invalid
);

    logic c_nan;
    logic c_snan;
    logic special;
    logic any_snan;

    assign c_nan    = three_op & fl_c.is_nan;
    assign c_snan   = three_op & fl_c.is_snan;
    assign special  = c_nan & zero_times_inf;
    assign any_snan = fl_a.is_snan | fl_b.is_snan | c_snan;

    always_comb begin
        pick    = PICK_NONE;
        invalid = any_snan;
        unique case (mode)
            MODE_STD: begin
                if (special) begin
                    pick    = c_snan ? PICK_C : PICK_DFLT;
                    invalid = 1'b1;
                end else if (three_op) begin
                    if      (c_snan)       pick = PICK_C;
                    else if (fl_a.is_snan) pick = PICK_A;
                    else if (fl_b.is_snan) pick = PICK_B;
                    else if (c_nan)        pick = PICK_C;
                    else if (fl_a.is_nan)  pick = PICK_A;
                    else if (fl_b.is_nan)  pick = PICK_B;
                end else begin
                    if      (fl_a.is_snan) pick = PICK_A;
                    else if (fl_b.is_snan) pick = PICK_B;
                    else if (fl_a.is_nan)  pick = PICK_A;
                    else if (fl_b.is_nan)  pick = PICK_B;
                end
            end
            MODE_ALT: begin
                if (special)          pick = PICK_C;
                else if (fl_a.is_nan) pick = PICK_A;
                else if (fl_b.is_nan) pick = PICK_B;
                else if (c_nan)       pick = PICK_C;
            end
            default: pick = PICK_NONE;
        endcase
    end

endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
    import nanprop_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic         three_op,
    input  logic         alt_mode,
    output logic         nan_valid,
    output logic [W-1:0] nan_result,
    output logic         invalid,
    output logic [W-1:0] default_nan
);

    localparam int NUM_OPS = 3;

    logic [W-1:0] ops     [NUM_OPS];
    logic [W-1:0] quieted [NUM_OPS];
    nan_flags_t   flags   [NUM_OPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        nanprop_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .operand (ops[i]),
            .flags   (flags[i]),
            .quieted (quieted[i])
        );
    end

    logic zero_times_inf;

    nanprop_zero_inf #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_zi (
        .mul_a          (op_a),
        .mul_b          (op_b),
        .zero_times_inf (zero_times_inf)
    );

    nan_mode_e mode;
    nan_pick_e pick;
    logic      invalid_c;

    assign mode = nan_mode_e'(alt_mode);

    nanprop_select u_sel (
        .fl_a           (flags[0]),
        .fl_b           (flags[1]),
        .fl_c           (flags[2]),
        .three_op       (three_op),
        .mode           (mode),
        .zero_times_inf (zero_times_inf),
        .pick           (pick),
        .invalid        (invalid_c)
    );

    logic [W-1:0] dflt_c;
    logic [W-1:0] result_c;
    logic         valid_c;

    assign dflt_c = {alt_mode, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    always_comb begin
        unique case (pick)
            PICK_A:    result_c = quieted[0];
            PICK_B:    result_c = quieted[1];
            PICK_C:    result_c = quieted[2];
            PICK_DFLT: result_c = dflt_c;
            default:   result_c = '0;
        endcase
    end

    assign valid_c = (pick != PICK_NONE);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    nan_valid   <= 1'b0;
                    nan_result  <= '0;
                    invalid     <= 1'b0;
                    default_nan <= '0;
                end else begin
                    nan_valid   <= valid_c;
                    nan_result  <= result_c;
                    invalid     <= invalid_c;
                    default_nan <= dflt_c;
                end
            end
        end else begin : g_comb
            assign nan_valid   = valid_c;
            assign nan_result  = result_c;
            assign invalid     = invalid_c;
            assign default_nan = dflt_c;
        end
    endgenerate

endmodule

// File: rtl/nanprop_checker.sv
module nanprop_checker #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] op_c,
    input logic         three_op,
    input logic         alt_mode,
    input logic         nan_valid,
    input logic [W-1:0] nan_result,
    input logic         invalid,
    input logic [W-1:0] default_nan
);

    logic [W-1:0] p_a, p_b, p_c;
    logic         p_three, p_alt, primed;

    generate
        if (REG_OUT) begin : g_pipe
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    primed  <= 1'b0;
                    p_a     <= '0;
                    p_b     <= '0;
                    p_c     <= '0;
                    p_three <= 1'b0;
                    p_alt   <= 1'b0;
                end else begin
                    primed  <= 1'b1;
                    p_a     <= op_a;
                    p_b     <= op_b;
                    p_c     <= op_c;
                    p_three <= three_op;
                    p_alt   <= alt_mode;
                end
            end
        end else begin : g_direct
            assign primed  = 1'b1;
            assign p_a     = op_a;
            assign p_b     = op_b;
            assign p_c     = op_c;
            assign p_three = three_op;
            assign p_alt   = alt_mode;
        end
    endgenerate

    function automatic logic is_nan(input logic [W-1:0] v);
        return (&v[W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
    endfunction

    function automatic logic is_snan(input logic [W-1:0] v);
        return is_nan(v) && !v[FRAC_W-1];
    endfunction

    function automatic logic [W-1:0] quiet(input logic [W-1:0] v);
        logic [W-1:0] v_q;
        v_q = v;
        v_q[FRAC_W-1] = 1'b1;
        return v_q;
    endfunction

    a_r2_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        nan_valid |-> (&nan_result[W-2:FRAC_W]) && nan_result[FRAC_W-1]);

    a_r1_invalid_needs_nan: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> nan_valid);

    a_r1_no_nan_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !is_nan(p_a) && !is_nan(p_b) && !(p_three && is_nan(p_c)))
        |-> !nan_valid && !invalid);

    a_r3_std_snan_a_first: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !p_alt && !p_three && is_snan(p_a)) |-> nan_result == quiet(p_a));

    a_r5_alt_a_first: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && p_alt && !p_three && is_nan(p_a)) |-> nan_result == quiet(p_a));

    a_r10_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && (is_snan(p_a) || is_snan(p_b))) |-> invalid);

    a_r9_default_sign: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> default_nan[W-1] == p_alt && default_nan[FRAC_W-1]);

endmodule

bind nanprop_unit nanprop_checker #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .REG_OUT (REG_OUT)
) u_nanprop_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_a        (op_a),
    .op_b        (op_b),
    .op_c        (op_c),
    .three_op    (three_op),
    .alt_mode    (alt_mode),
    .nan_valid   (nan_valid),
    .nan_result  (nan_result),
    .invalid     (invalid),
    .default_nan (default_nan)
);

// File: tb/tb_nanprop_unit.sv
`timescale 1ns/1ps
module tb_nanprop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        three_op = 1'b0, alt_mode = 1'b0;
    logic        nan_valid, invalid;
    logic [31:0] nan_result, default_nan;

    logic [15:0] h_a = '0, h_b = '0, h_c = '0;
    logic        h_three = 1'b0, h_alt = 1'b0;
    logic        h_valid, h_inv;
    logic [15:0] h_res, h_dflt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nanprop_unit #(.EXP_W(8), .FRAC_W(23), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .three_op(three_op), .alt_mode(alt_mode), .nan_valid(nan_valid),
        .nan_result(nan_result), .invalid(invalid), .default_nan(default_nan)
    );

    nanprop_unit #(.EXP_W(5), .FRAC_W(10), .REG_OUT(1'b0)) dut_h (
        .clk(clk), .rst_n(rst_n), .op_a(h_a), .op_b(h_b), .op_c(h_c),
        .three_op(h_three), .alt_mode(h_alt), .nan_valid(h_valid),
        .nan_result(h_res), .invalid(h_inv), .default_nan(h_dflt)
    );

    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] QA   = 32'h7FC0_0001;
    localparam logic [31:0] SA   = 32'h7F80_0005;
    localparam logic [31:0] QB   = 32'hFFC0_0002;
    localparam logic [31:0] SB   = 32'hFF80_0007;
    localparam logic [31:0] QC   = 32'h7FC0_0003;
    localparam logic [31:0] SC   = 32'h7F80_0009;
    localparam logic [31:0] DSTD = 32'h7FC0_0000;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        three;
        logic        alt;
        logic        v;
        logic [31:0] res;
        logic        inv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{ONE, ONE, ONE, 1'b1, 1'b0, 1'b0, 32'h0,        1'b0, 8'd1},  // R1 no NaN
        '{PZ,  PINF, ONE, 1'b1, 1'b0, 1'b0, 32'h0,       1'b0, 8'd1},  // R1 0*inf, no NaN addend
        '{QA,  SB,  ONE, 1'b0, 1'b0, 1'b1, 32'hFFC0_0007, 1'b1, 8'd3}, // R3 SNaN B beats QNaN A
        '{QA,  QB,  ONE, 1'b0, 1'b0, 1'b1, QA,           1'b0, 8'd3},  // R3
        '{SA,  SB,  ONE, 1'b0, 1'b0, 1'b1, 32'h7FC0_0005, 1'b1, 8'd3}, // R3
        '{32'hFF81_2345, ONE, ONE, 1'b0, 1'b0, 1'b1, 32'hFFC1_2345, 1'b1, 8'd2}, // R2 payload kept
        '{QA,  SB,  ONE, 1'b0, 1'b1, 1'b1, QA,           1'b1, 8'd5},  // R5
        '{ONE, SB,  ONE, 1'b0, 1'b1, 1'b1, 32'hFFC0_0007, 1'b1, 8'd5}, // R5
        '{QA,  SB,  QC,  1'b1, 1'b0, 1'b1, 32'hFFC0_0007, 1'b1, 8'd4}, // R4
        '{QA,  QB,  QC,  1'b1, 1'b0, 1'b1, QC,           1'b0, 8'd4},  // R4
        '{SA,  SB,  QC,  1'b1, 1'b0, 1'b1, 32'h7FC0_0005, 1'b1, 8'd4}, // R4
        '{QA,  QB,  ONE, 1'b1, 1'b0, 1'b1, QA,           1'b0, 8'd4},  // R4
        '{ONE, QB,  SC,  1'b1, 1'b1, 1'b1, QB,           1'b1, 8'd6},  // R6
        '{QA,  SB,  SC,  1'b1, 1'b1, 1'b1, QA,           1'b1, 8'd6},  // R6
        '{PZ,  PINF, QC, 1'b1, 1'b0, 1'b1, DSTD,         1'b1, 8'd7},  // R7
        '{NINF, NZ, SC,  1'b1, 1'b0, 1'b1, 32'h7FC0_0009, 1'b1, 8'd7}, // R7
        '{PZ,  PINF, QC, 1'b1, 1'b1, 1'b1, QC,           1'b0, 8'd8},  // R8
        '{PINF, PZ, SC,  1'b1, 1'b1, 1'b1, 32'h7FC0_0009, 1'b1, 8'd8}, // R8
        '{ONE, ONE, SC,  1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 8'd12}, // R12
        '{ONE, QB,  SC,  1'b0, 1'b1, 1'b1, QB,           1'b0, 8'd12}  // R12
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        // R11: outputs cleared during reset even with NaN inputs present
        op_a = SA; op_b = SB; three_op = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "reset valid", {31'b0, nan_valid}, 32'h0);
        check("R11", "reset result", nan_result, 32'h0);
        check("R11", "reset invalid", {31'b0, invalid}, 32'h0);
        rst_n = 1'b1;

        // Vector walk: one operation per cycle, modes alternate (R11)
        for (int i = 0; i < NV; i++) begin
            op_a = VECS[i].a; op_b = VECS[i].b; op_c = VECS[i].c;
            three_op = VECS[i].three; alt_mode = VECS[i].alt;
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check(tag, "valid", {31'b0, nan_valid}, {31'b0, VECS[i].v});
            check(tag, "result", nan_result, VECS[i].res);
            check(tag, "invalid", {31'b0, invalid}, {31'b0, VECS[i].inv});
            // R9 default pattern follows the mode of this operation
            check("R9", "default", default_nan, VECS[i].alt ? 32'hFFC0_0000 : DSTD);
        end

        // R10: signalling addend in alternate mode behind a quiet A
        op_a = QA; op_b = ONE; op_c = SC; three_op = 1'b1; alt_mode = 1'b1;
        @(negedge clk);
        check("R10", "invalid", {31'b0, invalid}, 32'h1);
        check("R10", "result", nan_result, QA);

        // R11: latency - output holds the previous result until the edge
        op_a = ONE; op_b = ONE; op_c = ONE;
        #1;
        check("R11", "hold before edge", nan_result, QA);
        @(negedge clk);
        check("R11", "after edge", {31'b0, nan_valid}, 32'h0);

        // R11: asynchronous reset in the middle of a stream
        op_a = SA;
        @(negedge clk);
        check("R11", "pre-reset", {31'b0, nan_valid}, 32'h1);
        rst_n = 1'b0;
        #1;
        check("R11", "mid reset valid", {31'b0, nan_valid}, 32'h0);
        check("R11", "mid reset default", default_nan, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // binary16, combinational copy
        h_a = 16'h7C01; h_b = 16'h3C00; h_three = 1'b0; h_alt = 1'b0;
        #1;
        check("R2", "h quieted", {16'b0, h_res}, 32'h0000_7E01);
        check("R10", "h invalid", {31'b0, h_inv}, 32'h1);
        h_a = 16'h8000; h_b = 16'hFC00; h_c = 16'h7E05; h_three = 1'b1;
        #1;
        check("R7", "h std default", {16'b0, h_res}, 32'h0000_7E00);
        h_alt = 1'b1;
        #1;
        check("R8", "h alt addend", {16'b0, h_res}, 32'h0000_7E05);
        check("R8", "h alt no invalid", {31'b0, h_inv}, 32'h0);
        check("R9", "h alt default", {16'b0, h_dflt}, 32'h0000_FE00);
        h_c = 16'hFC00;
        #1;
        check("R1", "h 0*inf no NaN", {31'b0, h_valid}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule